// File: doc/BRIEF.md
# NMI-Gated Transfer Activation Controller

This block sits between a set of interrupt sources and a data transfer engine. It decides when a pending request may start a transfer. It keeps one 8-bit control/status register. Bit 1 of that register is a sticky flag that records a non-maskable event: a watchdog expiry, a stopped oscillator, or either of two supply-voltage monitors. While the flag is set, no new transfer is launched. A transfer that is already running is left alone and completes normally.

Software clears the flag with a guarded sequence. It first reads the register and sees the flag as 1, then writes the flag bit as 0. A write of 1, or a read that returned 0, withdraws the permission. This prevents a blind write from discarding an event that software never observed.

The transfer engine appears only through its completion pulse. When the controller is idle and not blocked, it launches the lowest-numbered request that is both asserted and enabled. The launch is a one-cycle strobe that carries the source index. The controller stays busy until the engine reports completion.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `xfer_gnt` is 0 and `xfer_busy` is 0.
- R2: A 1 on any bit of `nm_evt` (bit 0 watchdog, 1 oscillator stop, 2 voltage monitor 1, 3 voltage monitor 2) makes `reg_rdata[1]` read 1 from the next cycle on.
- R3: A read cycle that returns `reg_rdata[1]` = 1 arms a clear permission. A later write with `reg_wdata[1]` = 0 clears the flag from the next cycle, provided no read returning 0 and no other write came in between. Every write consumes the permission. When a read and a write share a cycle, the write uses the permission held before that cycle.
- R4: A write of `reg_wdata[1]` = 0 without an armed permission, including one made after a read that returned 0, leaves the flag unchanged.
- R5: A write of `reg_wdata[1]` = 1 never changes the flag and withdraws any armed permission.
- R6: An event in the same cycle as a permitted clear wins, and the flag stays 1.
- R7: Bit 0 stores the value of `reg_wdata[0]` on every write and reads it back. Bits 7 to 2 always read 0.
- R8: In a cycle where the flag reads 1, no launch is decided, so `xfer_gnt` is 0 in the next cycle.
- R9: A flag that rises while `xfer_busy` is 1 does not end the transfer. `xfer_busy` stays 1 until `xfer_done`.
- R10: A launch raises `xfer_gnt` for exactly one cycle and sets `xfer_busy` in that same cycle. `xfer_busy` falls in the cycle after a `xfer_done` pulse. No launch is decided while busy. A `xfer_done` pulse while idle has no effect.
- R11: A launch picks the lowest index i with `act_req[i]` and `act_en[i]` both 1, and presents i on `xfer_idx` while `xfer_gnt` is 1. Requests whose enable is 0 are never launched.
- R12: A request held through a blocked period, whether blocked by the flag or by a busy engine, is launched once the block lifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nm_evt | input | N_EVT | Non-maskable event pulses |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| act_req | input | N_SRC | Activation requests, held by each source until launched |
| act_en | input | N_SRC | Per-source activation enable |
| xfer_done | input | 1 | Transfer engine completion pulse |
| xfer_gnt | output | 1 | One-cycle launch strobe |
| xfer_idx | output | IDX_W | Index of the launched source |
| xfer_busy | output | 1 | A launched transfer has not yet completed |

## Verification
The clear sequence is exercised in several orders, and each order separates a different fault:
- read-1 followed by write-0, which must clear;
- write-0 with no read;
- read-0, then an event, then write-0;
- read-1, write-1, then write-0;
- a clear that coincides with an event.

A flag that clears on any write fails the second and third orders. A permission that is never withdrawn fails the fourth. Dropping the event priority fails the fifth.

Launch selection is driven with request and enable masks in which the lowest asserted request is disabled, so a picker that ignores enables reports the wrong index. Requests are held across a flag-blocked period and across a busy period to show they launch once released. An event raised mid-transfer checks that busy is not cut short.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 1;
  localparam int RSV_BIT  = 0;
  localparam int N_EVT    = 4;
endpackage

// File: rtl/nmi_rst_sync.sv
module nmi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/nmi_flag_reg.sv
module nmi_flag_reg
  import nmi_gate_pkg::*;
#(
  parameter int NE = N_EVT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NE-1:0]    evt,
  input  logic             rd,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             flag
);
  logic flag_q, flag_d, flag_en;
  logic arm_q, arm_d, arm_en;
  logic rsv_q, rsv_d, rsv_en;
  logic evt_any, clr_ok;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    evt_any = |evt;
    clr_ok  = wr && !wdata[FLAG_BIT] && arm_q;
    flag_en = evt_any || clr_ok;
    flag_d  = evt_any;
    arm_en  = wr || rd;
    arm_d   = wr ? 1'b0 : flag_q;
    rsv_en  = wr;
    rsv_d   = wdata[RSV_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      rsv_q  <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (arm_en)  arm_q  <= arm_d;
      if (rsv_en)  rsv_q  <= rsv_d;
    end
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b == FLAG_BIT) begin : g_flag
      assign rdata[b] = flag_q;
    end else if (b == RSV_BIT) begin : g_rsv
      assign rdata[b] = rsv_q;
    end else begin : g_zero
      assign rdata[b] = 1'b0;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/nmi_src_pick.sv
module nmi_src_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N_SRC-1:0] below;
  logic [N_SRC-1:0] first;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N_SRC; i++) begin : g_chain
    assign below[i] = below[i-1] | pend[i-1];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_first
    assign first[i] = pend[i] & ~below[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/nmi_xfer_launch.sv
module nmi_xfer_launch #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [IDX_W-1:0] pick,
  input  logic             block,
  input  logic             done,
  output logic             gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             busy
);
  logic             launch;
  logic             gnt_q, gnt_d;
  logic             busy_q, busy_d, busy_en;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    launch  = any && !block && !busy_q;
    gnt_d   = launch;
    busy_en = launch || done;
    busy_d  = launch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      gnt_q <= gnt_d;
      if (busy_en) busy_q <= busy_d;
      if (launch)  idx_q  <= pick;
    end
  end

  assign gnt     = gnt_q;
  assign gnt_idx = idx_q;
  assign busy    = busy_q;
endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl
  import nmi_gate_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_EVT = nmi_gate_pkg::N_EVT,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] nm_evt,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0] act_req,
  input  logic [N_SRC-1:0] act_en,
  input  logic             xfer_done,
  output logic             xfer_gnt,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             xfer_busy
);
  logic             srst_n;
  logic             flag;
  logic             any;
  logic [IDX_W-1:0] pick;
  logic [N_SRC-1:0] pend;

  assign pend = act_req & act_en;

  nmi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  nmi_flag_reg #(.NE(N_EVT)) u_flag (
    .clk(clk), .rst_n(srst_n), .evt(nm_evt), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .flag(flag)
  );

  nmi_src_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .any(any), .idx(pick)
  );

  nmi_xfer_launch #(.IDX_W(IDX_W)) u_launch (
    .clk(clk), .rst_n(srst_n), .any(any), .pick(pick), .block(flag),
    .done(xfer_done), .gnt(xfer_gnt), .gnt_idx(xfer_idx), .busy(xfer_busy)
  );
endmodule

// File: rtl/nmi_gate_chk.sv
module nmi_gate_chk #(
  parameter int N_SRC = 8,
  parameter int N_EVT = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] nm_evt,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             xfer_done,
  input logic             xfer_gnt,
  input logic             xfer_busy
);
  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|nm_evt) |=> reg_rdata[1]);

  // R5
  wr_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[1] && !(|nm_evt)) |=> (reg_rdata[1] == $past(reg_rdata[1])));

  // R7
  always_comb begin
    if (rst_n) upper_zero_chk: assert (reg_rdata[7:2] == 6'b0);
  end

  // R8
  flag_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |=> !xfer_gnt);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !xfer_done) |=> xfer_busy);

  // R10
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gnt |=> !xfer_gnt);

  // R10
  no_gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> !xfer_gnt);

  // R10
  gnt_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gnt |-> xfer_busy);
endmodule

bind nmi_gate_ctrl nmi_gate_chk #(.N_SRC(N_SRC), .N_EVT(N_EVT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nm_evt(nm_evt), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
  .xfer_gnt(xfer_gnt), .xfer_busy(xfer_busy)
);

// File: tb/tb_nmi_gate_ctrl.sv
module tb_nmi_gate_ctrl;
  localparam int N = 8;
  localparam int NE = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] nm_evt = '0;
  logic          reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [N-1:0]  act_req = '0, act_en = '0;
  logic          xfer_done = 1'b0;
  logic          xfer_gnt, xfer_busy;
  logic [IW-1:0] xfer_idx;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit live = 1'b0;

  int m_flag, m_arm, m_bit0, m_busy, m_gnt, m_idx;

  always #2 clk = ~clk;

  nmi_gate_ctrl #(.N_SRC(N), .N_EVT(NE)) dut (
    .clk(clk), .rst_n(rst_n), .nm_evt(nm_evt), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_req(act_req), .act_en(act_en),
    .xfer_done(xfer_done), .xfer_gnt(xfer_gnt), .xfer_idx(xfer_idx), .xfer_busy(xfer_busy)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 0; m_arm <= 0; m_bit0 <= 0; m_busy <= 0; m_gnt <= 0; m_idx <= 0;
    end else begin
      int low;
      bit go, clr;
      low = -1;
      for (int k = N - 1; k >= 0; k--) if (act_req[k] && act_en[k]) low = k;
      go = (m_flag == 0) && (m_busy == 0) && (low >= 0);
      m_gnt <= go ? 1 : 0;
      if (go) m_idx <= low;
      if (go) m_busy <= 1; else if (xfer_done) m_busy <= 0;
      clr = reg_wr && !reg_wdata[1] && (m_arm == 1);
      if (nm_evt != 0) m_flag <= 1; else if (clr) m_flag <= 0;
      if (reg_wr) m_arm <= 0; else if (reg_rd) m_arm <= m_flag;
      if (reg_wr) m_bit0 <= reg_wdata[0];
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check(reg_rdata == 8'((m_flag << 1) | m_bit0), phase, "rdata",
            int'(reg_rdata), (m_flag << 1) | m_bit0);
      check(int'(xfer_gnt) == m_gnt, phase, "gnt", int'(xfer_gnt), m_gnt);
      check(int'(xfer_busy) == m_busy, phase, "busy", int'(xfer_busy), m_busy);
      if (m_gnt == 1) check(int'(xfer_idx) == m_idx, phase, "idx", int'(xfer_idx), m_idx);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog run-end actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input logic [NE-1:0] e, input bit rd, input bit wr,
                     input logic [7:0] wd, input bit dn);
    nm_evt = e; reg_rd = rd; reg_wr = wr; reg_wdata = wd; xfer_done = dn;
    @(negedge clk);
    nm_evt = '0; reg_rd = 0; reg_wr = 0; reg_wdata = '0; xfer_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check(reg_rdata == 8'h00, "R1", "rdata", int'(reg_rdata), 0);
    check(xfer_gnt == 1'b0 && xfer_busy == 1'b0, "R1", "gnt/busy",
          int'({xfer_gnt, xfer_busy}), 0);
    live = 1'b1;

    for (int i = 0; i < NE; i++) begin
      phase = "R2"; cyc(4'(1 << i), 0, 0, 8'h00, 0); idle(1);
      check(reg_rdata[1] == 1'b1, "R2", "flag", int'(reg_rdata[1]), 1);
      phase = "R3"; cyc('0, 1, 0, 8'h00, 0); cyc('0, 0, 1, 8'h00, 0); idle(1);
      check(reg_rdata[1] == 1'b0, "R3", "flag", int'(reg_rdata[1]), 0);
    end

    phase = "R4";
    cyc(4'b0001, 0, 0, 8'h00, 0); cyc('0, 0, 1, 8'h00, 0); idle(1);
    check(reg_rdata[1] == 1'b1, "R4", "flag", int'(reg_rdata[1]), 1);
    cyc('0, 1, 0, 8'h00, 0); cyc('0, 0, 1, 8'h00, 0);
    cyc('0, 1, 0, 8'h00, 0); cyc(4'b0100, 0, 0, 8'h00, 0); cyc('0, 0, 1, 8'h00, 0); idle(1);
    check(reg_rdata[1] == 1'b1, "R4", "flag after read-0", int'(reg_rdata[1]), 1);

    phase = "R5";
    cyc('0, 1, 0, 8'h00, 0); cyc('0, 0, 1, 8'h02, 0); cyc('0, 0, 1, 8'h00, 0); idle(1);
    check(reg_rdata[1] == 1'b1, "R5", "flag", int'(reg_rdata[1]), 1);

    phase = "R6";
    cyc('0, 1, 0, 8'h00, 0); cyc(4'b1000, 0, 1, 8'h00, 0); idle(1);
    check(reg_rdata[1] == 1'b1, "R6", "flag", int'(reg_rdata[1]), 1);
    phase = "R3";
    cyc('0, 1, 0, 8'h00, 0); cyc('0, 1, 1, 8'h00, 0); idle(1);

    phase = "R7";
    cyc('0, 0, 1, 8'hFD, 0); idle(1);
    check(reg_rdata == 8'h01, "R7", "rdata", int'(reg_rdata), 1);
    cyc('0, 0, 1, 8'hFC, 0); idle(1);
    check(reg_rdata == 8'h00, "R7", "rdata", int'(reg_rdata), 0);

    phase = "R11";
    act_en = 8'hFF; act_req = 8'b1011_0100; idle(1);
    check(xfer_gnt && xfer_idx == 3'd2, "R11", "idx", int'(xfer_idx), 2);
    act_req = '0; idle(2); cyc('0, 0, 0, 8'h00, 1); idle(1);
    act_en = 8'b1111_1011; act_req = 8'b1011_0100; idle(1);
    check(xfer_gnt && xfer_idx == 3'd4, "R11", "idx masked", int'(xfer_idx), 4);
    act_req = '0; cyc('0, 0, 0, 8'h00, 1); idle(1);

    phase = "R10";
    cyc('0, 0, 0, 8'h00, 1); idle(1);
    check(xfer_busy == 1'b0, "R10", "done idle", int'(xfer_busy), 0);
    act_en = 8'hFF; act_req = 8'h80; idle(1); act_req = 8'h01; idle(4);
    check(xfer_busy == 1'b1 && xfer_gnt == 1'b0, "R10", "held off",
          int'({xfer_busy, xfer_gnt}), 2);
    phase = "R12"; cyc('0, 0, 0, 8'h00, 1); idle(1);
    check(xfer_gnt && xfer_idx == 3'd0, "R12", "after busy", int'(xfer_idx), 0);
    act_req = '0;

    phase = "R9";
    cyc(4'b0010, 0, 0, 8'h00, 0); idle(3);
    check(xfer_busy == 1'b1, "R9", "busy kept", int'(xfer_busy), 1);
    cyc('0, 0, 0, 8'h00, 1); idle(1);

    phase = "R8";
    act_req = 8'h20; idle(5);
    check(xfer_gnt == 1'b0 && xfer_busy == 1'b0, "R8", "blocked",
          int'({xfer_gnt, xfer_busy}), 0);
    phase = "R12";
    cyc('0, 1, 0, 8'h00, 0); cyc('0, 0, 1, 8'h00, 0); idle(1);
    check(xfer_gnt && xfer_idx == 3'd5, "R12", "after clear", int'(xfer_idx), 5);
    act_req = '0; idle(2); cyc('0, 0, 0, 8'h00, 1); idle(3);

    live = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule